// File: doc/BRIEF.md
# Digital FLL Tap Controller

This block closes a frequency-locked loop around an oscillator by steering a 14-bit control word. The upper 9 bits form a coarse oscillator tap, and the lower 5 bits form a fine modulation counter. An increment that wraps the fine part from 31 to 0 carries into the tap. A decrement that wraps it from 0 to 31 borrows from the tap. Everything runs in one system clock domain. The oscillator and the reference each arrive as one-cycle strobes: `osc_tick` pulses once per oscillator cycle and `ref_tick` pulses once per raw reference cycle.

Inside the block, the reference strobe passes through a selectable reference divider, which defines the measurement period. The oscillator strobe passes through a selectable feedback divider. At the end of each period, the block compares the number of divided oscillator pulses with the multiplier. It then steps the word up by one if the oscillator is slow, steps it down by one if the oscillator is fast, and holds it if the count matches. It also reports:
- the live unlock condition,
- a sticky record of slow and fast events,
- a fault flag for a tap stuck at either end of its range.

Software may place a starting word directly while the loop is stopped.

Top module: `fll_tap_ctrl`

## Requirements
- R1: After reset, the tap is 256, the modulation value is 0, the unlock status is 00, the history is 00 and the fault flag is 0.
- R2: The reference divider code `ref_div_sel` selects the following ratios: 0 gives /1; 1, 2, 3, 4 and 5 give /32, /64, /128, /256 and /512; 6 gives /640; 7 gives /768. The period ends on the `ref_tick` that completes a group of that many ticks.
- R3: The feedback divider code `fb_div_sel` selects the following ratios: codes 0 to 5 give /1, /2, /4, /8, /16 and /32; 6 gives /40; 7 gives /48. A divided pulse is produced on the `osc_tick` that completes each group.
- R4: At each period end, with the loop enabled, the word changes as follows:
  - If the divided count in the period is below the multiplier, the word rises by one.
  - If the count is above the multiplier, the word falls by one.
  - If the count is equal, the word holds.
  
  The new word is visible after that clock edge. A divided pulse in the same cycle as the period end counts toward the next period.
- R5: The word is `{tap, modulation}`. A step up from modulation 31 gives modulation 0 and tap+1. A step down from modulation 0 gives modulation 31 and tap-1.
- R6: The word saturates at 0x0000 and 0x3FFF instead of wrapping.
- R7: A multiplier input of 0 acts as 1.
- R8: At each period end, the unlock status becomes one of three values: 00 (count equal), 01 (too slow) or 10 (too fast). It holds between period ends. While the fault flag is 1, the unlock status reads 11.
- R9: The fault flag is set one cycle after the tap equals 0 or 511. A `fault_clr` pulse clears it only if the tap is no longer at either end.
- R10: History bit 0 records a too-slow period and bit 1 records a too-fast period. Each bit stays set until cleared by its own bit of `his_clr`. An event in the same cycle as the clear wins.
- R11: While `loop_en` is 0, the word never steps. Both dividers and the period count restart from zero.
- R12: A load with `ld_en` writes `{ld_tap, ld_mod}` into the word on the next edge only while `loop_en` is 0. With the loop enabled, the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | Loop enable; 0 freezes the word and restarts counting |
| osc_tick | input | 1 | One strobe per oscillator cycle |
| ref_tick | input | 1 | One strobe per raw reference cycle |
| ref_div_sel | input | 3 | Reference divider code |
| fb_div_sel | input | 3 | Feedback divider code |
| mult_n | input | 10 | Multiplier, 0 taken as 1 |
| ld_en | input | 1 | Direct word load strobe |
| ld_tap | input | 9 | Tap value to load |
| ld_mod | input | 5 | Modulation value to load |
| his_clr | input | 2 | Per-bit clear of the unlock history |
| fault_clr | input | 1 | Clear request for the fault flag |
| tap | output | 9 | Coarse oscillator tap |
| modv | output | 5 | Fine modulation counter |
| unlock | output | 2 | Current unlock status |
| unlock_his | output | 2 | Sticky unlock history |
| fault | output | 1 | Tap-at-end fault flag |

## Verification
The period end and a divided oscillator pulse can land in the same cycle. The same is true of an unlock event and a software clear of the matching history bit. The bench provokes both by driving dense random strobes with random per-bit history clears, under many divider and multiplier settings. Its cycle model judges each clock edge on its own terms: a coincident feedback pulse must start the next count at one, and a coincident event must leave its history bit set.

// File: rtl/fll_pkg.sv
package fll_pkg;
  localparam int TAP_W  = 9;
  localparam int MOD_W  = 5;
  localparam int WORD_W = TAP_W + MOD_W;
  localparam int N_W    = 10;
  localparam int DIV_W  = 10;
  localparam int SEL_W  = 3;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    UNL_LOCKED = 2'b00,
    UNL_SLOW   = 2'b01,
    UNL_FAST   = 2'b10,
    UNL_RANGE  = 2'b11
  } unlock_e;

  // Feedback ratio: powers of two up to 32, then 40 and 48.
  function automatic logic [DIV_W-1:0] fb_ratio(input logic [SEL_W-1:0] code);
    logic [DIV_W-1:0] r;
    case (code)
      3'd6:    r = DIV_W'(40);
      3'd7:    r = DIV_W'(48);
      default: r = DIV_W'(1) << code;
    endcase
    return r;
  endfunction

  // Reference ratio: 1, then 32..512 in powers of two, then 640 and 768.
  function automatic logic [DIV_W-1:0] ref_ratio(input logic [SEL_W-1:0] code);
    logic [DIV_W-1:0] r;
    case (code)
      3'd0:    r = DIV_W'(1);
      3'd6:    r = DIV_W'(640);
      3'd7:    r = DIV_W'(768);
      default: r = DIV_W'(16) << code;
    endcase
    return r;
  endfunction

  function automatic logic [N_W-1:0] mult_eff(input logic [N_W-1:0] n);
    return (n == '0) ? N_W'(1) : n;
  endfunction

  // Saturating single step of the combined word.
  function automatic word_t word_step(input word_t w, input logic up, input logic dn);
    word_t r;
    r = w;
    if (up && (w != '1))      r = w + word_t'(1);
    else if (dn && (w != '0)) r = w - word_t'(1);
    return r;
  endfunction
endpackage

// File: rtl/fll_strobe_div.sv
module fll_strobe_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [DIV_W-1:0] ratio,
  output logic             pulse
);
  logic [DIV_W-1:0] cnt_q;
  logic             last;

  // A count at or beyond the final slot closes the group, so a ratio that
  // shrinks mid-group never stalls the divider.
  assign last  = (cnt_q >= (ratio - DIV_W'(1)));
  assign pulse = !clr && tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (tick)  cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/fll_period_meter.sv
module fll_period_meter #(
  parameter int CNT_W = 12,
  parameter int N_W   = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           fb_pulse,
  input  logic           period_end,
  input  logic [N_W-1:0] n_eff,
  output logic           too_slow,
  output logic           too_fast
);
  logic [CNT_W-1:0] meas_q;
  logic [CNT_W-1:0] n_ext;

  assign n_ext    = CNT_W'(n_eff);
  assign too_slow = period_end && (meas_q < n_ext);
  assign too_fast = period_end && (meas_q > n_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      meas_q <= '0;
    else if (clr)
      meas_q <= '0;
    else if (period_end)
      meas_q <= CNT_W'(fb_pulse);   // a coincident pulse opens the next count
    else if (fb_pulse && (meas_q != '1))
      meas_q <= meas_q + CNT_W'(1);
  end
endmodule

// File: rtl/fll_tap_word.sv
module fll_tap_word
  import fll_pkg::*;
#(
  parameter word_t RESET_WORD = word_t'(256 << MOD_W)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_up,
  input  logic  step_dn,
  input  logic  ld_fire,
  input  word_t ld_word,
  output word_t word
);
  word_t word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= RESET_WORD;
    else if (ld_fire) word_q <= ld_word;
    else              word_q <= word_step(word_q, step_up, step_dn);
  end

  assign word = word_q;
endmodule

// File: rtl/fll_tap_ctrl.sv
module fll_tap_ctrl
  import fll_pkg::*;
#(
  parameter int RESET_TAP = 256,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loop_en,
  input  logic             osc_tick,
  input  logic             ref_tick,
  input  logic [SEL_W-1:0] ref_div_sel,
  input  logic [SEL_W-1:0] fb_div_sel,
  input  logic [N_W-1:0]   mult_n,
  input  logic             ld_en,
  input  logic [TAP_W-1:0] ld_tap,
  input  logic [MOD_W-1:0] ld_mod,
  input  logic [1:0]       his_clr,
  input  logic             fault_clr,
  output logic [TAP_W-1:0] tap,
  output logic [MOD_W-1:0] modv,
  output logic [1:0]       unlock,
  output logic [1:0]       unlock_his,
  output logic             fault
);
  localparam word_t RESET_WORD = word_t'(RESET_TAP) << MOD_W;
  localparam logic [TAP_W-1:0] TAP_TOP = '1;

  // Named internal events, shared with the checker.
  logic    halt;
  logic    period_end;
  logic    fb_pulse;
  logic    too_slow;
  logic    too_fast;
  logic    ld_fire;
  logic    at_end;
  word_t   word_w;
  unlock_e unl_q;
  logic [1:0] his_q;
  logic    fault_q;

  assign halt    = !loop_en;
  assign ld_fire = ld_en && halt;

  fll_strobe_div #(.DIV_W(DIV_W)) u_ref_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (halt),
    .tick  (ref_tick),
    .ratio (ref_ratio(ref_div_sel)),
    .pulse (period_end)
  );

  fll_strobe_div #(.DIV_W(DIV_W)) u_fb_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (halt),
    .tick  (osc_tick),
    .ratio (fb_ratio(fb_div_sel)),
    .pulse (fb_pulse)
  );

  fll_period_meter #(.CNT_W(CNT_W), .N_W(N_W)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (halt),
    .fb_pulse   (fb_pulse),
    .period_end (period_end),
    .n_eff      (mult_eff(mult_n)),
    .too_slow   (too_slow),
    .too_fast   (too_fast)
  );

  fll_tap_word #(.RESET_WORD(RESET_WORD)) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_up (too_slow),
    .step_dn (too_fast),
    .ld_fire (ld_fire),
    .ld_word ({ld_tap, ld_mod}),
    .word    (word_w)
  );

  assign at_end = (word_w[WORD_W-1:MOD_W] == '0) || (word_w[WORD_W-1:MOD_W] == TAP_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q   <= UNL_LOCKED;
      his_q   <= 2'b00;
      fault_q <= 1'b0;
    end else begin
      if (period_end)
        unl_q <= too_slow ? UNL_SLOW : (too_fast ? UNL_FAST : UNL_LOCKED);
      his_q   <= (his_q & ~his_clr) | {too_fast, too_slow};
      fault_q <= at_end || (fault_q && !fault_clr);
    end
  end

  assign tap        = word_w[WORD_W-1:MOD_W];
  assign modv       = word_w[MOD_W-1:0];
  assign unlock     = fault_q ? UNL_RANGE : unl_q;
  assign unlock_his = his_q;
  assign fault      = fault_q;
endmodule

// File: rtl/fll_tap_ctrl_chk.sv
module fll_tap_ctrl_chk
  import fll_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             loop_en,
  input logic             period_end,
  input logic             ld_fire,
  input logic [TAP_W-1:0] ld_tap,
  input logic [MOD_W-1:0] ld_mod,
  input logic [TAP_W-1:0] tap,
  input logic [MOD_W-1:0] modv,
  input logic [1:0]       unlock,
  input logic [1:0]       unlock_his,
  input logic [1:0]       his_clr,
  input logic             fault
);
  word_t w;
  assign w = {tap, modv};

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> ((w == $past(w)) || (w == $past(w) + word_t'(1)) || (w == $past(w) - word_t'(1)))); // R4

  AST_FROZEN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !ld_fire) |=> $stable(w)); // R11

  AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !ld_fire) |=> $stable(w)); // R4

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> (w == $past({ld_tap, ld_mod}))); // R12

  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (unlock == 2'b11)); // R8

  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((tap == '0) || (tap == '1)) |=> fault); // R9

  AST_HIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (his_clr == 2'b00) |=> ((unlock_his & $past(unlock_his)) == $past(unlock_his))); // R10
endmodule

bind fll_tap_ctrl fll_tap_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .loop_en    (loop_en),
  .period_end (period_end),
  .ld_fire    (ld_fire),
  .ld_tap     (ld_tap),
  .ld_mod     (ld_mod),
  .tap        (tap),
  .modv       (modv),
  .unlock     (unlock),
  .unlock_his (unlock_his),
  .his_clr    (his_clr),
  .fault      (fault)
);

// File: tb/fll_tap_ctrl_tb.sv
module fll_tap_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, ot = 1'b0, rt = 1'b0, ld = 1'b0, fc = 1'b0;
  logic [2:0] rsel = '0, fsel = '0;
  logic [9:0] nn = 10'd1;
  logic [8:0] ldt = '0;
  logic [4:0] ldm = '0;
  logic [1:0] hc = '0;
  logic [8:0] tap;
  logic [4:0] modv;
  logic [1:0] unlock, his;
  logic       fault;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [13:0] m_word;
  logic [1:0]  m_unl, m_his;
  logic        m_flt;
  int          r_tot, o_tot, m_meas;

  always #10 clk = ~clk;

  fll_tap_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .loop_en(en), .osc_tick(ot), .ref_tick(rt),
    .ref_div_sel(rsel), .fb_div_sel(fsel), .mult_n(nn), .ld_en(ld),
    .ld_tap(ldt), .ld_mod(ldm), .his_clr(hc), .fault_clr(fc),
    .tap(tap), .modv(modv), .unlock(unlock), .unlock_his(his), .fault(fault)
  );

  function automatic int ref_n(input logic [2:0] c);
    int t [8] = '{1, 32, 64, 128, 256, 512, 640, 768};
    return t[c];
  endfunction

  function automatic int fb_n(input logic [2:0] c);
    int t [8] = '{1, 2, 4, 8, 16, 32, 40, 48};
    return t[c];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_word = 14'(256 << 5); m_unl = 0; m_his = 0; m_flt = 0;
    r_tot = 0; o_tot = 0; m_meas = 0;
  endtask

  task automatic model_edge();
    int  ne = (nn == 0) ? 1 : int'(nn);
    bit  up = 0, dn = 0, per, fbp;
    bit  fnext = (m_word[13:5] == 9'd0) || (m_word[13:5] == 9'd511) || (m_flt && !fc);
    if (!en) begin
      r_tot = 0; o_tot = 0; m_meas = 0;
      if (ld) m_word = {ldt, ldm};
    end else begin
      per = rt && (((r_tot + 1) % ref_n(rsel)) == 0);
      fbp = ot && (((o_tot + 1) % fb_n(fsel)) == 0);
      r_tot += int'(rt); o_tot += int'(ot);
      if (per) begin
        up = (m_meas < ne); dn = (m_meas > ne);
        m_unl = up ? 2'b01 : (dn ? 2'b10 : 2'b00);
        if (up && m_word != 14'h3FFF) m_word++;
        if (dn && m_word != 14'h0000) m_word--;
        m_meas = int'(fbp);
      end else if (fbp) m_meas++;
    end
    m_his = (m_his & ~hc) | {dn, up};
    m_flt = fnext;
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge.
  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, "/R4 word"}, {tap, modv}, m_word);
    chk({tag, "/R8 unlock"}, unlock, m_flt ? 3 : m_unl);
    chk({tag, "/R10 history"}, his, m_his);
    chk({tag, "/R9 fault"}, fault, m_flt);
  endtask

  task automatic load(input logic [8:0] t, input logic [4:0] m);
    en = 0; ld = 1; ldt = t; ldm = m; cyc("R12");
    ld = 0;
  endtask

  task automatic run_rand(input string tag, input int n, input int p_osc, input int p_ref);
    for (int i = 0; i < n; i++) begin
      ot = ($urandom_range(99) < p_osc);
      rt = ($urandom_range(99) < p_ref);
      hc = ($urandom_range(15) == 0) ? 2'($urandom_range(3)) : 2'b00;
      fc = ($urandom_range(7) == 0);
      cyc(tag);
    end
    ot = 0; rt = 0; hc = 0; fc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 tap", tap, 256); chk("R1 mod", modv, 0);
    chk("R1 unlock", unlock, 0); chk("R1 his", his, 0); chk("R1 fault", fault, 0);
    rst_n = 1;
    @(negedge clk);

    // R5 carry: mod 31 stepping up goes to tap+1, mod 0
    load(9'd100, 5'd31);
    en = 1; rsel = 0; fsel = 0; nn = 10'd5; rt = 1; cyc("R5");
    chk("R5 carry tap", tap, 101); chk("R5 carry mod", modv, 0);
    // R5 borrow: mod 0 stepping down
    load(9'd100, 5'd0);
    en = 1; rsel = 3'd1; nn = 10'd1; ot = 1; rt = 1;
    for (int i = 0; i < 32; i++) cyc("R5");
    chk("R5 borrow tap", tap, 99); chk("R5 borrow mod", modv, 31);
    ot = 0; rt = 0;

    // R12 load ignored while enabled
    en = 1; ld = 1; ldt = 9'd7; ldm = 5'd3; cyc("R12");
    chk("R12 ignored", {tap, modv}, {9'd99, 5'd31});
    ld = 0;

    // R6 top saturation and R9 fault, R8 code 11
    load(9'd511, 5'd31);
    en = 1; rsel = 0; nn = 10'd9; rt = 1;
    for (int i = 0; i < 4; i++) cyc("R6");
    chk("R6 top sat", {tap, modv}, 14'h3FFF);
    chk("R9 fault at top", fault, 1); chk("R8 range code", unlock, 3);
    fc = 1; cyc("R9"); fc = 0;
    chk("R9 clear blocked", fault, 1);
    rt = 0;
    // R6 bottom saturation
    load(9'd0, 5'd1);
    en = 1; rsel = 3'd1; nn = 10'd1; ot = 1; rt = 1;
    for (int i = 0; i < 100; i++) cyc("R6");
    chk("R6 bottom sat", {tap, modv}, 14'h0000);
    ot = 0; rt = 0;

    // R7 multiplier zero acts as one: one pulse per period reads locked
    load(9'd200, 5'd0);
    en = 1; rsel = 0; fsel = 0; nn = 10'd0; ot = 1; rt = 1;
    for (int i = 0; i < 6; i++) cyc("R7");
    fc = 1; cyc("R7"); fc = 0;
    chk("R7 locked", unlock, 0); chk("R7 hold", {tap, modv}, {9'd200, 5'd1});
    ot = 0; rt = 0;

    // R2 large reference ratios, R3 large feedback ratios
    for (int c = 6; c < 8; c++) begin
      load(9'd300, 5'd0);
      en = 1; rsel = 3'(c); fsel = 3'(c); nn = 10'(c == 6 ? 16 : 16);
      ot = 1; rt = 1;
      for (int i = 0; i < 1600; i++) cyc(c == 6 ? "R2" : "R3");
      ot = 0; rt = 0;
    end

    // R11 loop stopped: ticks have no effect on the word
    en = 0; ot = 1; rt = 1;
    for (int i = 0; i < 20; i++) cyc("R11");
    chk("R11 frozen", {tap, modv}, m_word);
    ot = 0; rt = 0;

    // random configurations
    for (int k = 0; k < 24; k++) begin
      load(9'($urandom_range(1, 510)), 5'($urandom_range(31)));
      en = 1;
      rsel = 3'($urandom_range(2));
      fsel = 3'($urandom_range(7));
      nn = 10'($urandom_range(0, 24));
      run_rand((k % 2) ? "R2" : "R3", 2500, $urandom_range(30, 100), $urandom_range(20, 100));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule